// File: doc/BRIEF.md
# Pending Interrupt Priority Arbiter

This block sits in front of a processor's exception entry logic and decides when an asynchronous interrupt is taken and which one. It watches three sources. The first is an enabled floating-point exception: the summary exception status bit is set while either of the two floating-point exception mode bits is set. The second is a level-sensitive external interrupt line. The third is a one-cycle decrementer expiry pulse. It keeps a pending flag for each source and applies a fixed priority. It then raises one delivery request, which carries a vector offset and the save/restore status bits the entry logic must OR in.

The request is held, with its vector and status bits stable, until the entry logic acknowledges it. Only one delivery is outstanding at any time. An external interrupt stays pending for as long as its line is high, and delivering it does not clear it. A decrementer expiry is remembered once and is consumed by its own delivery. The floating-point exception does not depend on the external-interrupt enable. The other two sources are considered only while that enable is set.

Top module: `irq_pend_arb`

## Requirements
- R1: While reset is low at a clock edge, the next state has `req_o`=0, `vec_off_o`=0 and `cause_o`=0, and all pending flags are cleared.
- R2: When no request is outstanding and the floating-point pending flag is set (registered from `fx_summary_i` AND any bit of `fx_mode_i`), the next cycle raises a request with `vec_off_o`=0x700 and `cause_o` holding exactly bit 20 (floating-point enabled) and bit 16 (subsequent instruction). This happens whatever `ext_en_i` is and whatever other sources are pending.
- R3: External and decrementer sources never raise a request while `ext_en_i` is 0. Once `ext_en_i` is 1 with a source pending and no request outstanding, a request follows on the next edge.
- R4: The external source wins over the decrementer. External delivers at 0x500 and decrementer at 0x900, both with `cause_o`=0.
- R5: The external pending flag copies `ext_level_i` one edge later. Delivery does not clear it, so an acknowledged external request is raised again while the line stays high.
- R6: The decrementer pending flag is set by a `dec_expire_i` pulse and cleared on the edge where a 0x900 request is acknowledged.
- R7: An outstanding request keeps `req_o`, `vec_off_o` and `cause_o` unchanged until the edge on which `ack_i` is 1. `ack_i` has no effect while no request is outstanding.
- R8: New triggers that arrive while a request is outstanding do not change it. They are evaluated only after the acknowledge, one cycle later at the earliest.
- R9: A `dec_expire_i` pulse in the same cycle as the acknowledge of a 0x900 request leaves the decrementer flag set, so a new 0x900 request follows.
- R10: A source input seen at edge k sets its pending flag at edge k, and the request rises at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_level_i | input | 1 | External interrupt level |
| dec_expire_i | input | 1 | Decrementer expiry pulse |
| ext_en_i | input | 1 | External-interrupt enable state bit |
| fx_mode_i | input | FX_MODES (2) | Floating-point exception mode bits |
| fx_summary_i | input | 1 | Floating-point summary exception status bit |
| ack_i | input | 1 | Entry logic has taken the request |
| req_o | output | 1 | Delivery request |
| vec_off_o | output | 12 | Vector offset of the request (0 when idle) |
| cause_o | output | CAUSE_W (32) | Status bits to set in the save/restore register |

## Verification
Directed sequences cover the cases below:
- An external line held with the enable off, then switched on. This separates gating from latency.
- A decrementer pulse landing behind a held external request. This separates priority from single-outstanding behaviour.
- A decrementer pulse coinciding with its own acknowledge. This separates one-shot clearing from loss of a new event.
- A floating-point exception with the enable off and the external line high. This shows that it bypasses the enable and takes top priority.

A long pseudo-random phase then mixes every input with random acknowledges. It is compared every clock against a behavioural model of flags and request, which catches ordering and hold errors that the directed sequences miss.

// File: rtl/irq_arb_pkg.sv
// Shared types and constants for the pending interrupt arbiter.
// Assumes vector offsets fit in 12 bits.
package irq_arb_pkg;
    localparam int VEC_W = 12;

    localparam logic [VEC_W-1:0] VEC_FPX = 12'h700;
    localparam logic [VEC_W-1:0] VEC_EXT = 12'h500;
    localparam logic [VEC_W-1:0] VEC_DEC = 12'h900;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_FPX  = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_DEC  = 2'd3
    } irq_src_e;
endpackage

// File: rtl/irq_src_track.sv
// Pending flag tracker: keeps one registered flag for each interrupt source.
// External and floating-point flags follow their level. The decrementer
// flag is sticky until cleared by delivery; a new expiry wins over the clear.
module irq_src_track #(
    parameter int FX_MODES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ext_level_i,
    input  logic                dec_expire_i,
    input  logic [FX_MODES-1:0] fx_mode_i,
    input  logic                fx_summary_i,
    input  logic                clr_dec_i,
    output logic                ext_pend_o,
    output logic                dec_pend_o,
    output logic                fx_pend_o
);
    logic fx_cond;

    // Floating-point exception is enabled when any mode bit is set.
    always_comb fx_cond = fx_summary_i & (|fx_mode_i);

    // Level-tracked flags for external and floating-point sources.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_pend_o <= 1'b0;
            fx_pend_o  <= 1'b0;
        end else begin
            ext_pend_o <= ext_level_i;
            fx_pend_o  <= fx_cond;
        end
    end

    // One-shot decrementer flag: set by expiry, cleared by its delivery.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dec_pend_o <= 1'b0;
        else if (dec_expire_i)
            dec_pend_o <= 1'b1;
        else if (clr_dec_i)
            dec_pend_o <= 1'b0;
    end
endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority selector: floating-point exception first (ignores the
// external enable), then external, then decrementer (both gated).
// Purely combinational; assumes flags come from registers.
module irq_prio_pick
    import irq_arb_pkg::*;
(
    input  logic     fx_pend_i,
    input  logic     ext_pend_i,
    input  logic     dec_pend_i,
    input  logic     ext_en_i,
    output irq_src_e win_o
);
    // Priority chain resolving the winning source.
    always_comb begin
        if (fx_pend_i)
            win_o = SRC_FPX;
        else if (ext_en_i && ext_pend_i)
            win_o = SRC_EXT;
        else if (ext_en_i && dec_pend_i)
            win_o = SRC_DEC;
        else
            win_o = SRC_NONE;
    end
endmodule

// File: rtl/irq_req_hold.sv
// Request holder: captures the winning source when idle and holds it until
// acknowledged, so only one delivery is outstanding. Encodes the vector
// offset and the status bits from the held source.
module irq_req_hold
    import irq_arb_pkg::*;
#(
    parameter int CAUSE_W = 32,
    parameter int FPE_POS = 20,
    parameter int NXT_POS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  irq_src_e           win_i,
    input  logic               ack_i,
    output irq_src_e           sel_o,
    output logic               req_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic [CAUSE_W-1:0] cause_o
);
    // Capture when idle, release on acknowledge, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_o <= SRC_NONE;
        else if (sel_o != SRC_NONE) begin
            if (ack_i)
                sel_o <= SRC_NONE;
        end else
            sel_o <= win_i;
    end

    // Decode the held source into request, vector and status bits.
    always_comb begin
        req_o   = (sel_o != SRC_NONE);
        cause_o = '0;
        unique case (sel_o)
            SRC_FPX: begin
                vec_o            = VEC_FPX;
                cause_o[FPE_POS] = 1'b1;
                cause_o[NXT_POS] = 1'b1;
            end
            SRC_EXT: vec_o = VEC_EXT;
            SRC_DEC: vec_o = VEC_DEC;
            default: vec_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_pend_arb.sv
// Top of the pending interrupt priority arbiter. Tracks sources, picks
// by fixed priority and holds one request until acknowledged.
// Assumes ack_i is only meaningful while req_o is high.
module irq_pend_arb
    import irq_arb_pkg::*;
#(
    parameter int FX_MODES = 2,
    parameter int CAUSE_W  = 32,
    parameter int FPE_POS  = 20,
    parameter int NXT_POS  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ext_level_i,
    input  logic                dec_expire_i,
    input  logic                ext_en_i,
    input  logic [FX_MODES-1:0] fx_mode_i,
    input  logic                fx_summary_i,
    input  logic                ack_i,
    output logic                req_o,
    output logic [VEC_W-1:0]    vec_off_o,
    output logic [CAUSE_W-1:0]  cause_o
);
    logic     ext_pend, dec_pend, fx_pend, clr_dec;
    irq_src_e win, cur_sel;

    // Decrementer delivery completes on the acknowledge of its request.
    always_comb clr_dec = req_o && ack_i && (cur_sel == SRC_DEC);

    irq_src_track #(.FX_MODES(FX_MODES)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_level_i  (ext_level_i),
        .dec_expire_i (dec_expire_i),
        .fx_mode_i    (fx_mode_i),
        .fx_summary_i (fx_summary_i),
        .clr_dec_i    (clr_dec),
        .ext_pend_o   (ext_pend),
        .dec_pend_o   (dec_pend),
        .fx_pend_o    (fx_pend)
    );

    irq_prio_pick u_pick (
        .fx_pend_i  (fx_pend),
        .ext_pend_i (ext_pend),
        .dec_pend_i (dec_pend),
        .ext_en_i   (ext_en_i),
        .win_o      (win)
    );

    irq_req_hold #(
        .CAUSE_W (CAUSE_W),
        .FPE_POS (FPE_POS),
        .NXT_POS (NXT_POS)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_i   (win),
        .ack_i   (ack_i),
        .sel_o   (cur_sel),
        .req_o   (req_o),
        .vec_o   (vec_off_o),
        .cause_o (cause_o)
    );
endmodule

// File: rtl/irq_pend_arb_chk.sv
// Assertion checker for irq_pend_arb, bound to every instance of the top.
// Observes ports and the internal pending flags.
module irq_pend_arb_chk
    import irq_arb_pkg::*;
#(
    parameter int CAUSE_W = 32,
    parameter int FPE_POS = 20,
    parameter int NXT_POS = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ext_level_i,
    input logic               dec_expire_i,
    input logic               ext_en_i,
    input logic               ack_i,
    input logic               req_o,
    input logic [VEC_W-1:0]   vec_off_o,
    input logic [CAUSE_W-1:0] cause_o,
    input logic               ext_pend,
    input logic               dec_pend,
    input logic               fx_pend
);
    a_r2_fpx_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && fx_pend) |=> (req_o && vec_off_o == VEC_FPX));

    a_r2_fpx_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && vec_off_o == VEC_FPX) |->
            (cause_o[FPE_POS] && cause_o[NXT_POS] && $countones(cause_o) == 2));

    a_r3_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && !ext_en_i && !fx_pend) |=> !req_o);

    a_r4_ext_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && !fx_pend && ext_en_i && ext_pend) |=> (vec_off_o == VEC_EXT));

    a_r4_no_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && vec_off_o != VEC_FPX) |-> (cause_o == '0));

    a_r5_ext_level: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (ext_pend == $past(ext_level_i)));

    a_r6_dec_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i && vec_off_o == VEC_DEC && !dec_expire_i) |=> !dec_pend);

    a_r9_dec_set: assert property (@(posedge clk) disable iff (!rst_n)
        dec_expire_i |=> dec_pend);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> (req_o && $stable(vec_off_o) && $stable(cause_o)));

    a_r8_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i) |=> !req_o);
endmodule

bind irq_pend_arb irq_pend_arb_chk #(
    .CAUSE_W (CAUSE_W),
    .FPE_POS (FPE_POS),
    .NXT_POS (NXT_POS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_level_i  (ext_level_i),
    .dec_expire_i (dec_expire_i),
    .ext_en_i     (ext_en_i),
    .ack_i        (ack_i),
    .req_o        (req_o),
    .vec_off_o    (vec_off_o),
    .cause_o      (cause_o),
    .ext_pend     (ext_pend),
    .dec_pend     (dec_pend),
    .fx_pend      (fx_pend)
);

// File: tb/test_irq_pend_arb.sv
// Bench for irq_pend_arb: a behavioural reference model is stepped at
// every clock and compared against the outputs at the following negedge.
module test_irq_pend_arb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_level_i = 1'b0, dec_expire_i = 1'b0, ext_en_i = 1'b0;
    logic [1:0]  fx_mode_i = 2'b00;
    logic        fx_summary_i = 1'b0, ack_i = 1'b0;
    logic        req_o;
    logic [11:0] vec_off_o;
    logic [31:0] cause_o;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // Model state: flags, outstanding request and its vector (0 = none).
    bit m_ext, m_dec, m_fx;
    int m_vec;

    always #4 clk = ~clk;

    irq_pend_arb i_irq_pend_arb (
        .clk(clk), .rst_n(rst_n), .ext_level_i(ext_level_i),
        .dec_expire_i(dec_expire_i), .ext_en_i(ext_en_i),
        .fx_mode_i(fx_mode_i), .fx_summary_i(fx_summary_i), .ack_i(ack_i),
        .req_o(req_o), .vec_off_o(vec_off_o), .cause_o(cause_o)
    );

    // Advance the model by one edge using the inputs applied before it.
    task automatic model_edge();
        bit n_ext, n_dec, n_fx;
        int n_vec;
        if (!rst_n) begin
            m_ext = 0; m_dec = 0; m_fx = 0; m_vec = 0;
            return;
        end
        n_ext = ext_level_i;
        n_fx  = fx_summary_i && (fx_mode_i != 2'b00);
        n_dec = m_dec;
        if (dec_expire_i) n_dec = 1;
        else if (m_vec == 'h900 && ack_i) n_dec = 0;
        n_vec = m_vec;
        if (m_vec != 0) begin
            if (ack_i) n_vec = 0;
        end else if (m_fx) n_vec = 'h700;
        else if (ext_en_i && m_ext) n_vec = 'h500;
        else if (ext_en_i && m_dec) n_vec = 'h900;
        m_ext = n_ext; m_dec = n_dec; m_fx = n_fx; m_vec = n_vec;
    endtask

    // Apply inputs, clock once, then compare outputs with the model.
    task automatic step(input bit ext, input bit dec, input bit en,
                        input bit [1:0] fm, input bit fs, input bit ack,
                        input string tag);
        logic [31:0] exp_cause;
        ext_level_i = ext; dec_expire_i = dec; ext_en_i = en;
        fx_mode_i = fm; fx_summary_i = fs; ack_i = ack;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        exp_cause = (m_vec == 'h700) ? ((32'h1 << 20) | (32'h1 << 16)) : 32'h0;
        n_cmp++;
        if (req_o !== (m_vec != 0) || vec_off_o !== m_vec[11:0] || cause_o !== exp_cause) begin
            n_bad++;
            $display("FAIL %s: req=%0b vec=%h cause=%h expected req=%0b vec=%h cause=%h",
                     tag, req_o, vec_off_o, cause_o, (m_vec != 0), m_vec[11:0], exp_cause);
        end
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state, with sources active during reset
        rst_n = 0;
        step(1, 1, 1, 2'b01, 1, 0, "R1 reset");
        step(1, 0, 1, 2'b01, 1, 0, "R1 reset");
        step(0, 0, 0, 2'b00, 0, 0, "R1 reset");
        rst_n = 1;
        step(0, 0, 0, 2'b00, 0, 0, "R1 idle after reset");
        step(0, 0, 0, 2'b00, 0, 1, "R7 ack while idle");
        // R3: external held, enable off: nothing
        for (int i = 0; i < 4; i++) step(1, 0, 0, 2'b00, 0, 0, "R3 gated");
        // R3/R10: enable on -> request one edge later
        step(1, 0, 1, 2'b00, 0, 0, "R3 R10 enable rise");
        // R7/R8: hold while decrementer arrives
        step(1, 1, 1, 2'b00, 0, 0, "R8 dec behind ext");
        step(1, 0, 1, 2'b00, 0, 0, "R7 hold");
        step(1, 0, 1, 2'b00, 0, 0, "R7 hold");
        step(1, 0, 1, 2'b00, 0, 1, "R7 ack ext");
        // R5: external still high -> raised again
        step(1, 0, 1, 2'b00, 0, 0, "R5 re-raise");
        step(0, 0, 1, 2'b00, 0, 0, "R5 ext redelivered");
        step(0, 0, 1, 2'b00, 0, 1, "R5 ack ext line low");
        // R4: decrementer now delivered at 0x900
        step(0, 0, 1, 2'b00, 0, 0, "R4 dec next");
        step(0, 0, 1, 2'b00, 0, 0, "R4 dec request");
        // R9: new expiry coinciding with ack keeps pending
        step(0, 1, 1, 2'b00, 0, 1, "R9 ack with new expiry");
        step(0, 0, 1, 2'b00, 0, 0, "R9 dec again");
        step(0, 0, 1, 2'b00, 0, 1, "R6 ack dec");
        // R6: flag consumed -> no further request
        for (int i = 0; i < 3; i++) step(0, 0, 1, 2'b00, 0, 0, "R6 one shot");
        // R2: fp exception with enable off and external high
        step(1, 0, 0, 2'b10, 1, 0, "R2 fp raise");
        step(1, 0, 0, 2'b10, 1, 0, "R2 fp request");
        step(1, 0, 0, 2'b00, 0, 1, "R2 ack fp");
        step(1, 0, 1, 2'b00, 0, 0, "R2 R4 ext after fp");
        step(1, 0, 1, 2'b00, 0, 0, "R4 ext request");
        step(0, 0, 1, 2'b01, 0, 1, "R2 summary off no fp");
        step(0, 0, 1, 2'b00, 1, 0, "R2 mode off no fp");
        step(0, 0, 1, 2'b00, 1, 0, "R2 mode off no fp");
        // Random mix of all inputs (R2..R10)
        for (int i = 0; i < 3000; i++)
            step($urandom_range(0, 1), ($urandom_range(0, 5) == 0), ($urandom_range(0, 3) != 0),
                 2'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0),
                 $urandom_range(0, 1), "R8 random mix");
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule